// File: doc/BRIEF.md
# Floating-Point Upper-Word Transfer Unit

This block keeps a bank of 32 floating-point registers, each 64 bits wide, and carries out two transfers between that bank and the integer side. A *fetch-high* instruction returns the upper 32-bit word of a floating-point register as a sign-extended 64-bit integer result. A *store-high* instruction takes the low 32 bits of an integer operand and writes them into the upper word of a floating-point register. A mode input selects how the register file is organized. In wide mode, each register is a full 64-bit value. In paired mode, each register holds one 32-bit value in its low word, and an even register forms a 64-bit pair with the odd register above it.

In paired mode, the upper word of an even register is its odd partner. Naming an odd register in paired mode is illegal, but it does not trap. A fetch returns a fixed poison word. A store writes a different poison word into the named register. Both cases raise a warning for the cycle in which the instruction is presented.

Reads are combinational from the current register contents. Writes land on the rising clock edge, so a fetch in the next cycle sees them. The integer register index from the instruction is passed through so that the surrounding pipeline can steer the result or fetch the operand.

Top module: `fhh_move_unit`

## Requirements
- R1: A synchronous active-low reset clears every floating-point register to zero. After reset, every fetch in wide mode returns 0, and every fetch from an even register in paired mode returns 0.
- R2: An instruction is accepted only when `instr_valid_i` is high and all of the following hold:
  - bits 31:26 equal 010001;
  - bits 25:21 equal 00011 (fetch-high) or 00111 (store-high);
  - bits 10:0 are zero.

  Any other word, or a low valid, changes no register and keeps `gpr_valid_o` and `odd_warn_o` low.
- R3: In wide mode (`fr64_mode_i`=1), a fetch from register fs (bits 15:11) returns bits 63:32 of that register, sign-extended to 64 bits.
- R4: In wide mode, a store to register fs replaces bits 63:32 of fs with `gpr_lo_i` and leaves bits 31:0 of fs unchanged.
- R5: In paired mode (`fr64_mode_i`=0) with an even fs, a fetch returns the low word of register fs+1, sign-extended.
- R6: In paired mode with an even fs, a store writes `gpr_lo_i` into the low word of register fs+1. The upper word of fs+1 and all of register fs are left unchanged.
- R7: In paired mode with an odd fs, a fetch returns 0x000000000BADF00D.
- R8: In paired mode with an odd fs, a store writes 0xDEADC0DE into the low word of register fs itself. A later fetch of the even register fs-1 returns 0xFFFFFFFFDEADC0DE.
- R9: `odd_warn_o` is high exactly in the cycle in which an accepted instruction names an odd fs in paired mode. It is low for every other instruction and in wide mode.
- R10: `gpr_valid_o` is high only while an accepted fetch is presented, with `gpr_o` valid combinationally in that same cycle. A store is visible to a fetch in the following cycle. `gpr_idx_o` always shows bits 20:16 of the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all register writes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid_i | input | 1 | Instruction word is present this cycle |
| instr_i | input | 32 | Instruction word |
| gpr_lo_i | input | 32 | Low word of the integer source operand |
| fr64_mode_i | input | 1 | 1 = wide 64-bit registers, 0 = paired 32-bit registers |
| gpr_o | output | 64 | Sign-extended integer result of a fetch |
| gpr_valid_o | output | 1 | `gpr_o` carries a fetch result |
| gpr_idx_o | output | 5 | Integer register index (instruction bits 20:16) |
| odd_warn_o | output | 1 | Illegal odd-register access in paired mode |

## Verification
The hardest state to reach from the ports is a register whose low and upper words came from different writers. Examples are a low word left by a paired-mode store or a poison store, beneath an upper word written in wide mode. Only such a register shows whether each kind of store really preserves the other half. The stimulus therefore switches the mode at random on every instruction, across a long seeded run. It also adds directed sequences that store in one mode and fetch the same bits back through the other mode's addressing, including fetching a poisoned odd register through its even partner.

// File: rtl/fhh_pkg.sv
// Package: shared constants for the floating-point upper-word transfer unit.
// Assumes a 32-bit instruction word with the major opcode in bits 31:26.
package fhh_pkg;
    localparam int unsigned NREG_DEF  = 32;
    localparam int unsigned FPW_DEF   = 64;
    localparam logic [5:0]  OPC_COP   = 6'b010001;
    localparam logic [4:0]  SUB_FETCH = 5'b00011;
    localparam logic [4:0]  SUB_STORE = 5'b00111;
    localparam logic [31:0] POISON_FETCH = 32'h0BADF00D;
    localparam logic [31:0] POISON_STORE = 32'hDEADC0DE;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_FETCH = 2'd1,
        OP_STORE = 2'd2
    } fhh_op_e;
endpackage

// File: rtl/fhh_decode.sv
// Module: fhh_decode
// Recognises the two transfer instructions and splits out their register fields.
// Assumes fields: rt in bits 20:16, fs in bits 15:11, bits 10:0 reserved zero.
module fhh_decode
    import fhh_pkg::*;
#(
    parameter int unsigned NREG = NREG_DEF,
    localparam int unsigned AW  = $clog2(NREG)
) (
    input  logic          valid_i,
    input  logic [31:0]   instr_i,
    output fhh_op_e       op_o,
    output logic [4:0]    rt_o,
    output logic [AW-1:0] fs_o
);
    logic match_base;

    // Purpose: qualify the fixed opcode and reserved fields.
    always_comb begin
        match_base = valid_i && (instr_i[31:26] == OPC_COP) && (instr_i[10:0] == 11'd0);
    end

    // Purpose: classify the sub-opcode into the operation kind.
    always_comb begin
        op_o = OP_NONE;
        if (match_base) begin
            if (instr_i[25:21] == SUB_FETCH)      op_o = OP_FETCH;
            else if (instr_i[25:21] == SUB_STORE) op_o = OP_STORE;
        end
    end

    assign rt_o = instr_i[20:16];
    assign fs_o = instr_i[11 +: AW];
endmodule

// File: rtl/fhh_regfile.sv
// Module: fhh_regfile
// Bank of NREG registers with one combinational read port and one write port
// that writes the upper half, the lower half, or (not used here) both.
// Assumes a synchronous active-low reset that zeroes every entry.
module fhh_regfile #(
    parameter int unsigned NREG = 32,
    parameter int unsigned FPW  = 64,
    localparam int unsigned AW   = $clog2(NREG),
    localparam int unsigned HALF = FPW / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_hi_i,
    input  logic            we_lo_i,
    input  logic [AW-1:0]   waddr_i,
    input  logic [HALF-1:0] wdata_i,
    input  logic [AW-1:0]   raddr_i,
    output logic [FPW-1:0]  rdata_o
);
    logic [FPW-1:0]  q [NREG];
    logic [NREG-1:0] sel;

    // Per-entry address match for the write port.
    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign sel[g] = (waddr_i == AW'(g));
    end

    // Purpose: reset the bank or apply the half-word write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n) begin
                q[i] <= '0;
            end else if (sel[i]) begin
                if (we_hi_i) q[i][FPW-1:HALF] <= wdata_i;
                if (we_lo_i) q[i][HALF-1:0]   <= wdata_i;
            end
        end
    end

    assign rdata_o = q[raddr_i];

    // R4
    hi_write_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_hi_i && !we_lo_i) |=> (q[$past(waddr_i)][HALF-1:0] == $past(q[waddr_i][HALF-1:0])));

    // R6
    lo_write_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_lo_i && !we_hi_i) |=> (q[$past(waddr_i)][FPW-1:HALF] == $past(q[waddr_i][FPW-1:HALF])));
endmodule

// File: rtl/fhh_route.sv
// Module: fhh_route
// Maps an operation and the register mode onto register-file addresses, write
// enables and the sign-extended result, including the odd-register poison cases.
// Assumes NREG is even, so every even index has an odd partner.
module fhh_route
    import fhh_pkg::*;
#(
    parameter int unsigned NREG = NREG_DEF,
    parameter int unsigned FPW  = FPW_DEF,
    localparam int unsigned AW   = $clog2(NREG),
    localparam int unsigned HALF = FPW / 2
) (
    input  fhh_op_e         op_i,
    input  logic [AW-1:0]   fs_i,
    input  logic            wide_i,
    input  logic [HALF-1:0] opnd_i,
    input  logic [FPW-1:0]  rdata_i,
    output logic [AW-1:0]   raddr_o,
    output logic [AW-1:0]   waddr_o,
    output logic            we_hi_o,
    output logic            we_lo_o,
    output logic [HALF-1:0] wdata_o,
    output logic [FPW-1:0]  result_o,
    output logic            valid_o,
    output logic            warn_o
);
    logic            odd_pair;
    logic [AW-1:0]   partner;
    logic [HALF-1:0] word;

    assign odd_pair = !wide_i && fs_i[0];
    assign partner  = {fs_i[AW-1:1], 1'b1};

    // Purpose: choose the source word for a fetch.
    always_comb begin
        raddr_o = wide_i ? fs_i : partner;
        if (wide_i)        word = rdata_i[FPW-1:HALF];
        else if (odd_pair) word = POISON_FETCH[HALF-1:0];
        else               word = rdata_i[HALF-1:0];
        result_o = {{HALF{word[HALF-1]}}, word};
    end

    // Purpose: steer a store to the right register half and data.
    always_comb begin
        we_hi_o = 1'b0;
        we_lo_o = 1'b0;
        waddr_o = fs_i;
        wdata_o = opnd_i;
        if (op_i == OP_STORE) begin
            if (wide_i) begin
                we_hi_o = 1'b1;
            end else if (odd_pair) begin
                we_lo_o = 1'b1;
                wdata_o = POISON_STORE[HALF-1:0];
            end else begin
                we_lo_o = 1'b1;
                waddr_o = partner;
            end
        end
    end

    assign valid_o = (op_i == OP_FETCH);
    assign warn_o  = (op_i != OP_NONE) && odd_pair;
endmodule

// File: rtl/fhh_move_unit.sv
// Module: fhh_move_unit (top)
// Floating-point upper-word transfer unit: decode, route and register bank.
// Assumes the caller holds instr_valid_i high for one cycle per instruction.
module fhh_move_unit
    import fhh_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        instr_valid_i,
    input  logic [31:0] instr_i,
    input  logic [31:0] gpr_lo_i,
    input  logic        fr64_mode_i,
    output logic [63:0] gpr_o,
    output logic        gpr_valid_o,
    output logic [4:0]  gpr_idx_o,
    output logic        odd_warn_o
);
    localparam int unsigned NREG = NREG_DEF;
    localparam int unsigned FPW  = FPW_DEF;
    localparam int unsigned AW   = $clog2(NREG);
    localparam int unsigned HALF = FPW / 2;

    fhh_op_e         op;
    logic [AW-1:0]   fs, raddr, waddr;
    logic            we_hi, we_lo;
    logic [HALF-1:0] wdata;
    logic [FPW-1:0]  rdata;

    fhh_decode #(.NREG(NREG)) u_decode (
        .valid_i (instr_valid_i),
        .instr_i (instr_i),
        .op_o    (op),
        .rt_o    (gpr_idx_o),
        .fs_o    (fs)
    );

    fhh_route #(.NREG(NREG), .FPW(FPW)) u_route (
        .op_i     (op),
        .fs_i     (fs),
        .wide_i   (fr64_mode_i),
        .opnd_i   (gpr_lo_i),
        .rdata_i  (rdata),
        .raddr_o  (raddr),
        .waddr_o  (waddr),
        .we_hi_o  (we_hi),
        .we_lo_o  (we_lo),
        .wdata_o  (wdata),
        .result_o (gpr_o),
        .valid_o  (gpr_valid_o),
        .warn_o   (odd_warn_o)
    );

    fhh_regfile #(.NREG(NREG), .FPW(FPW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_hi_i (we_hi),
        .we_lo_i (we_lo),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );

    // R9
    warn_needs_paired_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        odd_warn_o |-> (!fr64_mode_i && instr_i[11] && instr_valid_i));

    // R10
    fetch_never_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_valid_o |-> !(we_hi || we_lo));

    // R2
    idle_is_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid_i |-> !(gpr_valid_o || odd_warn_o || we_hi || we_lo));

    // R8
    odd_store_poisons_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (odd_warn_o && we_lo) |-> (wdata == POISON_STORE && waddr == instr_i[15:11]));
endmodule

// File: tb/test_fhh_move_unit.sv
module test_fhh_move_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] gpr_lo_i = '0;
    logic        fr64_mode_i = 1'b1;
    logic [63:0] gpr_o;
    logic        gpr_valid_o;
    logic [4:0]  gpr_idx_o;
    logic        odd_warn_o;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    logic [63:0] model [32];

    always #5 clk = ~clk;

    fhh_move_unit i_fhh_move_unit (.*);

    function automatic logic [31:0] mk(input logic [4:0] sub, input logic [4:0] rt, input logic [4:0] fs);
        return {6'b010001, sub, rt, fs, 11'd0};
    endfunction

    function automatic logic [63:0] sx(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    function automatic logic [63:0] exp_fetch(input logic [4:0] fs, input logic wide);
        if (wide) return sx(model[fs][63:32]);
        if (fs[0]) return 64'h0000_0000_0BAD_F00D;
        return sx(model[fs | 5'd1][31:0]);
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Present one instruction for one cycle, check outputs, update the model.
    task automatic run(input string tag, input logic [31:0] ins, input logic [31:0] opnd,
                       input logic wide, input logic legal);
        logic [4:0] fs;
        logic fetch, store;
        fs    = ins[15:11];
        fetch = legal && ins[25:21] == 5'b00011;
        store = legal && ins[25:21] == 5'b00111;
        @(negedge clk);
        instr_valid_i = 1'b1; instr_i = ins; gpr_lo_i = opnd; fr64_mode_i = wide;
        #1;
        chk({tag, " valid"}, {63'd0, gpr_valid_o}, {63'd0, fetch});
        chk({tag, " warn R9"}, {63'd0, odd_warn_o}, {63'd0, (fetch || store) && !wide && fs[0]});
        chk({tag, " idx R10"}, {59'd0, gpr_idx_o}, {59'd0, ins[20:16]});
        if (fetch) chk({tag, " data"}, gpr_o, exp_fetch(fs, wide));
        @(posedge clk);
        if (store) begin
            if (wide)       model[fs][63:32] = opnd;
            else if (fs[0]) model[fs][31:0]  = 32'hDEADC0DE;
            else            model[fs | 5'd1][31:0] = opnd;
        end
        @(negedge clk);
        instr_valid_i = 1'b0;
        #1;
        chk({tag, " idle valid R2"}, {62'd0, gpr_valid_o, odd_warn_o}, 64'd0);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state in both modes
        for (int f = 0; f < 32; f++) run("R1 wide", mk(5'b00011, 5'd1, 5'(f)), 0, 1'b1, 1'b1);
        for (int f = 0; f < 32; f += 2) run("R1 paired", mk(5'b00011, 5'd2, 5'(f)), 0, 1'b0, 1'b1);

        // R3/R4: wide store, upper replaced, low untouched (low set via paired store first)
        run("R6 paired store", mk(5'b00111, 5'd3, 5'd4), 32'h1234_5678, 1'b0, 1'b1);
        run("R4 wide store", mk(5'b00111, 5'd3, 5'd5), 32'h8765_4321, 1'b1, 1'b1);
        run("R3 wide fetch neg", mk(5'b00011, 5'd3, 5'd5), 0, 1'b1, 1'b1);
        run("R4 low kept", mk(5'b00011, 5'd3, 5'd4), 0, 1'b0, 1'b1);
        run("R6 reg4 untouched", mk(5'b00011, 5'd3, 5'd4), 0, 1'b1, 1'b1);
        run("R5 wide pos", mk(5'b00111, 5'd7, 5'd31), 32'h7FFF_FFFF, 1'b1, 1'b1);
        run("R3 wide fetch pos", mk(5'b00011, 5'd7, 5'd31), 0, 1'b1, 1'b1);

        // R5/R6: paired even store and fetch, upper of partner kept
        run("R6 paired store neg", mk(5'b00111, 5'd9, 5'd30), 32'hF000_0001, 1'b0, 1'b1);
        run("R5 paired fetch", mk(5'b00011, 5'd9, 5'd30), 0, 1'b0, 1'b1);
        run("R6 upper kept", mk(5'b00011, 5'd9, 5'd31), 0, 1'b1, 1'b1);

        // R7/R8: odd register in paired mode
        run("R7 odd fetch", mk(5'b00011, 5'd11, 5'd13), 0, 1'b0, 1'b1);
        run("R8 odd store", mk(5'b00111, 5'd11, 5'd13), 32'h0000_1111, 1'b0, 1'b1);
        run("R8 poison seen", mk(5'b00011, 5'd11, 5'd12), 0, 1'b0, 1'b1);
        run("R9 wide odd no warn", mk(5'b00011, 5'd11, 5'd13), 0, 1'b1, 1'b1);

        // R2: malformed words have no effect
        run("R2 bad low bit", mk(5'b00111, 5'd1, 5'd2) | 32'h1, 32'hAAAA_AAAA, 1'b0, 1'b0);
        run("R2 bad opcode", mk(5'b00111, 5'd1, 5'd3) ^ 32'h8000_0000, 32'hAAAA_AAAA, 1'b1, 1'b0);
        run("R2 unchanged", mk(5'b00011, 5'd1, 5'd2), 0, 1'b0, 1'b1);
        run("R2 unchanged wide", mk(5'b00011, 5'd1, 5'd3), 0, 1'b1, 1'b1);

        // R10 and mixed modes: seeded random run
        for (int k = 0; k < 600; k++) begin
            logic [31:0] ins;
            logic [4:0]  fs;
            int unsigned kind, b;
            fs   = 5'($urandom_range(0, 31));
            kind = $urandom_range(0, 9);
            ins  = mk((kind < 4) ? 5'b00011 : 5'b00111, 5'($urandom), fs);
            if (kind == 9) begin
                b = $urandom_range(0, 16);
                ins[(b < 11) ? b : b + 15] = ~ins[(b < 11) ? b : b + 15];
                run("R2 random bad", ins, $urandom, 1'($urandom), 1'b0);
            end else begin
                run("R10 random", ins, $urandom, 1'($urandom), 1'b1);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule